// File: doc/BRIEF.md
# VPID-Tagged Translation Cache with Sweep Invalidation

This block is a small fully associative translation cache. Each entry holds a 16-bit virtual-processor tag, a global flag, a linear page number, a physical page number and a valid bit. A lookup port translates a linear address for the virtual processor that is currently running. A fill port, driven by an external page walker, installs new translations.

A command port removes translations selectively by virtual-processor tag. It has four kinds: a single address, a single context, every non-zero context, and a single context that keeps its global entries. A command is carried out as a sweep that visits one entry per clock, starting at index 0. While the sweep runs the block reports busy. It pulses done in the last cycle of the sweep.

Lookup and fill are valid/ready streams. A transfer happens in a cycle where both valid and ready are high. Both ready signals, and the command port's ready, are low for the whole sweep, so nothing can enter or leave the cache while entries are being cleared. The same stall applies to the command port itself. A source that sees ready low must hold its request until ready returns.

Top module: `vtlb_inval_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. After reset busy and done are low, and lk_ready, fl_ready and inv_ready are high.
- R2: A lookup hits in the same cycle when an entry is valid, its tag equals cur_vpid, and its page number equals lk_laddr above bit 12. The low 12 offset bits and the global flag have no effect. On a hit, lk_ppn returns the stored physical page. If several entries match, the lowest index wins.
- R3: A fill writes the lowest-indexed invalid entry. When all entries are valid, the fill writes the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such an eviction.
- R4: Command kind 0 (inv_kind 2'b00) clears the valid entries whose tag equals inv_vpid and whose page number equals that of inv_laddr. This includes global entries.
- R5: Command kind 1 (2'b01) clears every valid entry whose tag equals inv_vpid.
- R6: Command kind 2 (2'b10) clears every entry with a non-zero tag. Entries tagged 0 are kept.
- R7: Command kind 3 (2'b11) clears every entry tagged inv_vpid except the entries whose global flag is set.
- R8: A command is taken when inv_valid and inv_ready are both high. Busy is high for exactly N_ENT cycles, starting in the next cycle. Done is high only in the last of those cycles.
- R9: While busy is high, lk_ready, fl_ready and inv_ready are low. Lookups report no hit, and fill requests are not stored.
- R10: A fill taken in the same cycle as a command is stored before the sweep begins, so the sweep applies to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_vpid | input | 16 | Tag of the running virtual processor, used by lookups |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted (low during a sweep) |
| lk_laddr | input | 48 | Linear address to translate |
| lk_hit | output | 1 | Lookup transfer hit this cycle |
| lk_ppn | output | 28 | Physical page number on a hit |
| fl_valid | input | 1 | Fill request |
| fl_ready | output | 1 | Fill accepted (low during a sweep) |
| fl_vpid | input | 16 | Tag of the new entry |
| fl_laddr | input | 48 | Linear address of the new entry |
| fl_ppn | input | 28 | Physical page number of the new entry |
| fl_global | input | 1 | Global flag of the new entry |
| inv_valid | input | 1 | Invalidation command request |
| inv_ready | output | 1 | Command accepted (high when idle) |
| inv_kind | input | 2 | Command kind, 0..3 |
| inv_vpid | input | 16 | Tag operand of the command |
| inv_laddr | input | 48 | Address operand of kind 0 |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse in the last sweep cycle |

## Verification
The hardest case to reach is an invalidation sweep on a full cache that has already evicted entries round-robin. In that state a translation's index no longer follows the order of fills, and duplicate tag/page pairs sit at different indices. Random traffic reaches this state by drawing tags from four values and pages from four values, so the cache fills, wraps and aliases within a few dozen operations. After every command the stimulus looks up all sixteen tag/page pairs. Directed cases cover the same-cycle fill-and-command race and fills offered during a sweep. A fill offered during a sweep uses a tag that is never otherwise used, so any leak of that fill into the cache shows up as a hit.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;
  typedef enum logic [1:0] {
    INV_ADDR      = 2'd0,
    INV_CTX       = 2'd1,
    INV_ALL_NZ    = 2'd2,
    INV_CTX_LOCAL = 2'd3
  } inv_kind_e;
endpackage

// File: rtl/vtlb_inv_match.sv
`timescale 1ns/1ps
module vtlb_inv_match
  import vtlb_pkg::*;
#(
  parameter int VPID_W = 16,
  parameter int LPN_W  = 36
) (
  input  inv_kind_e           kind,
  input  logic [VPID_W-1:0]   cmd_vpid,
  input  logic [LPN_W-1:0]    cmd_lpn,
  input  logic                ent_vld,
  input  logic [VPID_W-1:0]   ent_vpid,
  input  logic [LPN_W-1:0]    ent_lpn,
  input  logic                ent_glb,
  output logic                clr
);
  logic tag_eq;
  logic page_eq;
  logic tag_nz;

  assign tag_eq  = (ent_vpid == cmd_vpid);
  assign page_eq = (ent_lpn == cmd_lpn);
  assign tag_nz  = |ent_vpid;

  always_comb begin
    clr = 1'b0;
    if (ent_vld) begin
      unique case (kind)
        INV_ADDR:      clr = tag_eq && page_eq;
        INV_CTX:       clr = tag_eq;
        INV_ALL_NZ:    clr = tag_nz;
        INV_CTX_LOCAL: clr = tag_eq && !ent_glb;
        default:       clr = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vtlb_victim.sv
`timescale 1ns/1ps
module vtlb_victim #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] vld_vec,
  input  logic             take,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_nxt;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign rr_nxt = (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
  assign victim = free_found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && !free_found) begin
      rr_q <= rr_nxt;
    end
  end

  // Pointer only moves on an eviction
  assert_rr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(&vld_vec)) |=> $stable(rr_q));
  assert_rr_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&vld_vec)) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/vtlb_sweep.sv
`timescale 1ns/1ps
module vtlb_sweep #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (idx_q == LAST) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = busy_q && (idx_q == LAST);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_sweep_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (idx == '0));
  assert_sweep_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && (idx == $past(idx) + 1'b1)));
endmodule

// File: rtl/vtlb_inval_top.sv
`timescale 1ns/1ps
module vtlb_inval_top
  import vtlb_pkg::*;
#(
  parameter int N_ENT    = 8,
  parameter int VPID_W   = 16,
  parameter int LA_W     = 48,
  parameter int PA_W     = 40,
  parameter int PG_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VPID_W-1:0]        cur_vpid,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [LA_W-1:0]          lk_laddr,
  output logic                     lk_hit,
  output logic [PA_W-PG_SHIFT-1:0] lk_ppn,
  input  logic                     fl_valid,
  output logic                     fl_ready,
  input  logic [VPID_W-1:0]        fl_vpid,
  input  logic [LA_W-1:0]          fl_laddr,
  input  logic [PA_W-PG_SHIFT-1:0] fl_ppn,
  input  logic                     fl_global,
  input  logic                     inv_valid,
  output logic                     inv_ready,
  input  logic [1:0]               inv_kind,
  input  logic [VPID_W-1:0]        inv_vpid,
  input  logic [LA_W-1:0]          inv_laddr,
  output logic                     busy,
  output logic                     done
);
  localparam int LPN_W = LA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // Entry storage
  logic [N_ENT-1:0]  vld_q;
  logic [VPID_W-1:0] vpid_q [N_ENT];
  logic [LPN_W-1:0]  lpn_q  [N_ENT];
  logic [PPN_W-1:0]  ppn_q  [N_ENT];
  logic              glb_q  [N_ENT];

  // Latched command
  inv_kind_e         k_q;
  logic [VPID_W-1:0] cv_q;
  logic [LPN_W-1:0]  cl_q;

  logic             inv_fire;
  logic             fl_fire;
  logic [IDX_W-1:0] sw_idx;
  logic [IDX_W-1:0] fl_idx;
  logic             sw_clr;

  logic [LPN_W-1:0] lk_lpn;
  logic [LPN_W-1:0] fl_lpn;
  logic [N_ENT-1:0] lk_match;
  logic             lk_any;
  logic [PPN_W-1:0] lk_sel;

  logic unused_offsets;
  assign unused_offsets = ^{lk_laddr[PG_SHIFT-1:0], fl_laddr[PG_SHIFT-1:0],
                            inv_laddr[PG_SHIFT-1:0]};

  // Stream handshakes
  assign lk_ready  = !busy;
  assign fl_ready  = !busy;
  assign inv_ready = !busy;
  assign inv_fire  = inv_valid && inv_ready;
  assign fl_fire   = fl_valid && fl_ready;

  assign lk_lpn = lk_laddr[LA_W-1:PG_SHIFT];
  assign fl_lpn = fl_laddr[LA_W-1:PG_SHIFT];

  // Sweep sequencer
  vtlb_sweep #(.N_ENT(N_ENT)) sweep_u (
    .clk   (clk),
    .rst_n (rst_n),
    .start (inv_fire),
    .busy  (busy),
    .done  (done),
    .idx   (sw_idx)
  );

  // Replacement choice
  vtlb_victim #(.N_ENT(N_ENT)) victim_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_vec (vld_q),
    .take    (fl_fire),
    .victim  (fl_idx)
  );

  // One shared match unit, fed with the entry under the sweep pointer
  vtlb_inv_match #(.VPID_W(VPID_W), .LPN_W(LPN_W)) match_u (
    .kind     (k_q),
    .cmd_vpid (cv_q),
    .cmd_lpn  (cl_q),
    .ent_vld  (busy && vld_q[sw_idx]),
    .ent_vpid (vpid_q[sw_idx]),
    .ent_lpn  (lpn_q[sw_idx]),
    .ent_glb  (glb_q[sw_idx]),
    .clr      (sw_clr)
  );

  // Command latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q  <= INV_ADDR;
      cv_q <= '0;
      cl_q <= '0;
    end else if (inv_fire) begin
      k_q  <= inv_kind_e'(inv_kind);
      cv_q <= inv_vpid;
      cl_q <= inv_laddr[LA_W-1:PG_SHIFT];
    end
  end

  // Entry update: fill when idle, clear during the sweep
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        vpid_q[i] <= '0;
        lpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        glb_q[i]  <= 1'b0;
      end
    end else begin
      if (sw_clr) begin
        vld_q[sw_idx] <= 1'b0;
      end
      if (fl_fire) begin
        vld_q[fl_idx]  <= 1'b1;
        vpid_q[fl_idx] <= fl_vpid;
        lpn_q[fl_idx]  <= fl_lpn;
        ppn_q[fl_idx]  <= fl_ppn;
        glb_q[fl_idx]  <= fl_global;
      end
    end
  end

  // Lookup compare, one per entry
  for (genvar g = 0; g < N_ENT; g++) begin : g_lk
    assign lk_match[g] = vld_q[g] && (vpid_q[g] == cur_vpid) && (lpn_q[g] == lk_lpn);
  end

  // Lowest index wins
  always_comb begin
    lk_any = 1'b0;
    lk_sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_any = 1'b1;
        lk_sel = ppn_q[i];
      end
    end
  end

  assign lk_hit = lk_valid && lk_ready && lk_any;
  assign lk_ppn = lk_hit ? lk_sel : '0;

  // Assertions
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !fl_ready && !inv_ready && !lk_hit));
  assert_no_cmd_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    assert_clear_in_sweep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vld_q[g]) |-> $past(busy));
    assert_set_by_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q[g]) |-> $past(fl_valid && !busy));
    assert_kind_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vld_q[g]) && (k_q == INV_ADDR)) |-> ((vpid_q[g] == cv_q) && (lpn_q[g] == cl_q)));
    assert_kind_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vld_q[g]) && (k_q == INV_CTX)) |-> (vpid_q[g] == cv_q));
    assert_kind_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vld_q[g]) && (k_q == INV_ALL_NZ)) |-> (vpid_q[g] != '0));
    assert_kind_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vld_q[g]) && (k_q == INV_CTX_LOCAL)) |-> (!glb_q[g] && (vpid_q[g] == cv_q)));
  end
endmodule

// File: tb/vtlb_inval_top_tb_top.sv
`timescale 1ns/1ps
module vtlb_inval_top_tb_top;
  localparam int N_ENT = 8;
  localparam int VW    = 16;
  localparam int LA_W  = 48;
  localparam int PG    = 12;
  localparam int LPN_W = LA_W - PG;
  localparam int PPN_W = 40 - PG;
  localparam logic [VW-1:0] BAD_TAG = 16'h0BAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0]    cur_vpid = '0;
  logic             lk_valid = 1'b0;
  logic             lk_ready;
  logic [LA_W-1:0]  lk_laddr = '0;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic             fl_valid = 1'b0;
  logic             fl_ready;
  logic [VW-1:0]    fl_vpid = '0;
  logic [LA_W-1:0]  fl_laddr = '0;
  logic [PPN_W-1:0] fl_ppn = '0;
  logic             fl_global = 1'b0;
  logic             inv_valid = 1'b0;
  logic             inv_ready;
  logic [1:0]       inv_kind = '0;
  logic [VW-1:0]    inv_vpid = '0;
  logic [LA_W-1:0]  inv_laddr = '0;
  logic             busy;
  logic             done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vtlb_inval_top #(.N_ENT(N_ENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_vpid(cur_vpid),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_laddr(lk_laddr),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_vpid(fl_vpid),
    .fl_laddr(fl_laddr), .fl_ppn(fl_ppn), .fl_global(fl_global),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_kind(inv_kind),
    .inv_vpid(inv_vpid), .inv_laddr(inv_laddr),
    .busy(busy), .done(done)
  );

  // Reference model
  logic             m_vld  [N_ENT];
  logic [VW-1:0]    m_vpid [N_ENT];
  logic [LPN_W-1:0] m_lpn  [N_ENT];
  logic [PPN_W-1:0] m_ppn  [N_ENT];
  logic             m_glb  [N_ENT];
  int               m_rr;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N_ENT; i++) begin
      m_vld[i] = 1'b0; m_vpid[i] = '0; m_lpn[i] = '0; m_ppn[i] = '0; m_glb[i] = 1'b0;
    end
    m_rr = 0;
  endtask

  task automatic model_fill(input logic [VW-1:0] v, input logic [LPN_W-1:0] p,
                            input logic [PPN_W-1:0] pp, input logic g);
    int slot = -1;
    for (int i = 0; i < N_ENT; i++) if (slot < 0 && !m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N_ENT;
    end
    m_vld[slot] = 1'b1; m_vpid[slot] = v; m_lpn[slot] = p;
    m_ppn[slot] = pp; m_glb[slot] = g;
  endtask

  task automatic model_inv(input logic [1:0] k, input logic [VW-1:0] v,
                           input logic [LPN_W-1:0] p);
    for (int i = 0; i < N_ENT; i++) begin
      logic c;
      case (k)
        2'd0: c = (m_vpid[i] == v) && (m_lpn[i] == p);
        2'd1: c = (m_vpid[i] == v);
        2'd2: c = (m_vpid[i] != '0);
        default: c = (m_vpid[i] == v) && !m_glb[i];
      endcase
      if (c) m_vld[i] = 1'b0;
    end
  endtask

  function automatic logic [PPN_W:0] model_look(input logic [VW-1:0] v,
                                                input logic [LPN_W-1:0] p);
    for (int i = 0; i < N_ENT; i++)
      if (m_vld[i] && m_vpid[i] == v && m_lpn[i] == p) return {1'b1, m_ppn[i]};
    return '0;
  endfunction

  function automatic logic [LA_W-1:0] mk_addr(input logic [LPN_W-1:0] p);
    return {p, 12'($urandom)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_fill(input logic [VW-1:0] v, input logic [LPN_W-1:0] p,
                         input logic [PPN_W-1:0] pp, input logic g);
    @(negedge clk);
    fl_valid = 1'b1; fl_vpid = v; fl_laddr = mk_addr(p); fl_ppn = pp; fl_global = g;
    #1;
    chk("R9", "fl_ready idle", 64'(fl_ready), 64'd1);
    @(posedge clk);
    model_fill(v, p, pp, g);
    #1;
    fl_valid = 1'b0;
  endtask

  task automatic do_look(input string req, input logic [VW-1:0] v,
                         input logic [LPN_W-1:0] p);
    logic [PPN_W:0] e;
    @(negedge clk);
    cur_vpid = v; lk_valid = 1'b1; lk_laddr = mk_addr(p);
    #1;
    e = model_look(v, p);
    chk(req, $sformatf("hit v=%0h p=%0h", v, p), 64'(lk_hit), 64'(e[PPN_W]));
    if (e[PPN_W]) chk(req, "ppn", 64'(lk_ppn), 64'(e[PPN_W-1:0]));
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
  endtask

  task automatic scan(input string req);
    for (int v = 0; v < 4; v++)
      for (int p = 0; p < 4; p++)
        do_look(req, VW'(v), LPN_W'(p));
    do_look("R9", BAD_TAG, LPN_W'(7));
  endtask

  // Command with full timing checks; optional fill in the accept cycle (R10)
  task automatic do_inv(input string req, input logic [1:0] k, input logic [VW-1:0] v,
                        input logic [LPN_W-1:0] p, input bit with_fill,
                        input logic [VW-1:0] fv, input logic [LPN_W-1:0] fp,
                        input logic [PPN_W-1:0] fpp, input logic fg);
    @(negedge clk);
    inv_valid = 1'b1; inv_kind = k; inv_vpid = v; inv_laddr = mk_addr(p);
    if (with_fill) begin
      fl_valid = 1'b1; fl_vpid = fv; fl_laddr = mk_addr(fp); fl_ppn = fpp; fl_global = fg;
    end
    #1;
    chk("R8", "inv_ready idle", 64'(inv_ready), 64'd1);
    @(posedge clk);
    if (with_fill) model_fill(fv, fp, fpp, fg);
    #1;
    inv_valid = 1'b0; fl_valid = 1'b0;
    for (int c = 0; c < N_ENT; c++) begin
      @(negedge clk);
      fl_valid = 1'b1; fl_vpid = BAD_TAG; fl_laddr = mk_addr(LPN_W'(7));
      fl_ppn = PPN_W'(28'hBAD); fl_global = 1'b0;
      lk_valid = 1'b1; cur_vpid = fv; lk_laddr = mk_addr(fp);
      inv_valid = 1'b1;
      #1;
      chk("R8", $sformatf("busy c=%0d", c), 64'(busy), 64'd1);
      chk("R8", $sformatf("done c=%0d", c), 64'(done), 64'(c == N_ENT - 1));
      chk("R9", "readys low", 64'({lk_ready, fl_ready, inv_ready, lk_hit}), 64'd0);
    end
    @(negedge clk);
    fl_valid = 1'b0; lk_valid = 1'b0; inv_valid = 1'b0;
    #1;
    chk("R8", "busy after sweep", 64'({busy, done}), 64'd0);
    model_inv(k, v, p);
    scan(req);
  endtask

  task automatic do_inv_plain(input string req, input logic [1:0] k,
                              input logic [VW-1:0] v, input logic [LPN_W-1:0] p);
    do_inv(req, k, v, p, 1'b0, '0, '0, '0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0101);
    model_reset();
    do_reset();

    // R1 reset state
    #1;
    chk("R1", "busy/done", 64'({busy, done}), 64'd0);
    chk("R1", "readys", 64'({lk_ready, fl_ready, inv_ready}), 64'b111);
    do_look("R1", 16'd0, '0);
    do_look("R1", 16'd1, '0);

    // R2 lookup, offsets and global ignored, tag must match
    do_fill(16'd1, 36'd1, 28'h111, 1'b1);
    do_fill(16'd2, 36'd1, 28'h222, 1'b0);
    do_look("R2", 16'd1, 36'd1);
    do_look("R2", 16'd2, 36'd1);
    do_look("R2", 16'd3, 36'd1);
    do_look("R2", 16'd1, 36'd2);
    // duplicate pair: lowest index wins
    do_fill(16'd1, 36'd1, 28'h999, 1'b0);
    do_look("R2", 16'd1, 36'd1);

    // R3 fill order and round-robin eviction
    do_reset();
    for (int i = 0; i < N_ENT; i++) do_fill(16'd3, LPN_W'(i + 16), PPN_W'(i + 1), 1'b0);
    do_fill(16'd3, 36'd40, 28'h40, 1'b0);
    do_look("R3", 16'd3, 36'd16);
    do_look("R3", 16'd3, 36'd17);
    do_fill(16'd3, 36'd41, 28'h41, 1'b0);
    do_look("R3", 16'd3, 36'd17);
    do_look("R3", 16'd3, 36'd18);
    do_look("R3", 16'd3, 36'd41);

    // Directed kinds on a known mix
    do_reset();
    do_fill(16'd0, 36'd0, 28'hA0, 1'b0);
    do_fill(16'd1, 36'd0, 28'hA1, 1'b1);
    do_fill(16'd1, 36'd1, 28'hA2, 1'b0);
    do_fill(16'd2, 36'd0, 28'hA3, 1'b1);
    do_fill(16'd2, 36'd1, 28'hA4, 1'b0);
    do_fill(16'd3, 36'd2, 28'hA5, 1'b0);
    do_inv_plain("R4", 2'd0, 16'd1, 36'd0);
    do_inv_plain("R7", 2'd3, 16'd2, 36'd0);
    do_inv_plain("R5", 2'd1, 16'd1, 36'd3);
    do_inv_plain("R6", 2'd2, 16'd0, 36'd0);

    // R10 fill in the accept cycle is swept
    do_reset();
    do_fill(16'd2, 36'd2, 28'hB0, 1'b0);
    do_inv("R10", 2'd1, 16'd2, 36'd0, 1'b1, 16'd2, 36'd3, 28'hB1, 1'b0);
    do_inv("R10", 2'd1, 16'd1, 36'd0, 1'b1, 16'd2, 36'd1, 28'hB2, 1'b1);

    // Constrained random traffic
    do_reset();
    for (int it = 0; it < 250; it++) begin
      int op;
      logic [VW-1:0] v;
      logic [LPN_W-1:0] p;
      op = $urandom_range(0, 9);
      v  = VW'($urandom_range(0, 3));
      p  = LPN_W'($urandom_range(0, 3));
      if (op < 5) begin
        do_fill(v, p, PPN_W'($urandom), 1'($urandom));
      end else if (op < 8) begin
        do_look("R2", v, p);
      end else begin
        logic [1:0] k;
        k = 2'($urandom);
        case (k)
          2'd0: do_inv("R4", k, v, p, 1'($urandom), VW'($urandom_range(0, 3)),
                       LPN_W'($urandom_range(0, 3)), PPN_W'($urandom), 1'($urandom));
          2'd1: do_inv_plain("R5", k, v, p);
          2'd2: do_inv_plain("R6", k, v, p);
          default: do_inv_plain("R7", k, v, p);
        endcase
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule